// File: doc/BRIEF.md
# GPIO Interrupt Detector

This block is the interrupt half of one bank of a general-purpose I/O controller. It watches a word of already-synchronized pin inputs and, for each pin, decides whether an interrupt event happened. Three per-pin configuration bits control the decision. The type bit chooses between edge and level sensing. The polarity bit chooses the rising edge or high level when set, and the falling edge or low level when clear. The both-edges bit makes an edge-sensing pin fire on either transition.

Events are latched in a sticky status word. Software clears it by writing ones to the status address. A per-pin mask suppresses pins from the single interrupt output, and the mask is never written directly. Writing ones to a write-only unmask address clears mask bits, and writing ones to a write-only mask address sets them. The interrupt output is high while any status bit whose mask bit is clear is set.

Access is through a plain strobe bus. Writes take effect on the clock edge that samples `wr_en`. Read data appears on `rdata` on the edge after `rd_en` is sampled.

Top module: `pin_event_irq`

## Requirements
- R1: After reset, every mask bit is 1, the status, type, polarity and both-edges words are all 0, and `irq` is low.
- R2: Byte offsets are fixed: mask 0x20C (read only), unmask 0x210 (write only), mask-set 0x214 (write only), status 0x218, type 0x21C, polarity 0x220, both-edges 0x224. The type, polarity and both-edges words read back what was last written. The two write-only addresses read as zero. Read data is valid on the clock edge after the read strobe.
- R3: With its type bit at 1, a pin with polarity 1 latches a status bit on a 0-to-1 change and ignores 1-to-0 changes. With polarity 0 it latches on a 1-to-0 change and ignores 0-to-1 changes.
- R4: With both type and both-edges bits at 1, a pin latches on either transition whatever its polarity bit is. With type 0, the both-edges bit has no effect.
- R5: With its type bit at 0, a pin's status bit is set on every cycle its input equals its polarity bit. A write-1 clear does not remove it while that level persists, and the clear succeeds once the level has gone.
- R6: Writing the status address clears exactly the bits written as 1 and leaves the bits written as 0 unchanged.
- R7: When an event and a write-1 clear hit the same status bit in the same cycle, the bit stays set.
- R8: Writing ones to the unmask address clears those mask bits, and writing ones to the mask-set address sets them. Bits written as 0 are unchanged. A write to the mask address itself has no effect. Writing all ones to the mask-set address masks every pin.
- R9: `irq` equals the OR over all pins of status AND NOT mask. It changes on the same clock edge as the status or mask change that causes it.
- R10: A masked pin still records its events in the status word. Unmasking it later with the event still latched raises `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Synchronized pin levels |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Byte address within the bank |
| wdata | input | NPINS | Write data |
| rdata | output | NPINS | Registered read data |
| irq | output | 1 | Interrupt request, high while any unmasked status bit is set |

## Verification
The hardest case to reach from the ports is a write-1 clear landing in the same cycle as a new edge on the same pin. The bench gets there by changing the pin and raising the status-clear write on the same falling clock edge, so both are sampled by one rising edge. Reading the status afterwards must still show the bit.

A second delicate case is a level-type pin that is still active when software clears it. The bench issues the clear while the level is held, reads the bit back still set, and clears again only after removing the level. Masked events are checked by latching a pin while masked and then unmasking it to see `irq` rise with no new edge.

// File: rtl/pei_pkg.sv
package pei_pkg;

  // Register byte offsets within one bank
  localparam int OFF_MASK  = 'h20C;
  localparam int OFF_UNMSK = 'h210;
  localparam int OFF_MSET  = 'h214;
  localparam int OFF_STAT  = 'h218;
  localparam int OFF_TYPE  = 'h21C;
  localparam int OFF_POL   = 'h220;
  localparam int OFF_BOTH  = 'h224;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_UNMSK,
    SEL_MSET,
    SEL_STAT,
    SEL_TYPE,
    SEL_POL,
    SEL_BOTH
  } reg_sel_e;

endpackage

// File: rtl/pei_decode.sv
module pei_decode #(
  parameter int AW = 12
) (
  input  logic [AW-1:0]       addr,
  output pei_pkg::reg_sel_e   sel
);
  import pei_pkg::*;

  always_comb begin
    if      (addr == AW'(OFF_MASK))  sel = SEL_MASK;
    else if (addr == AW'(OFF_UNMSK)) sel = SEL_UNMSK;
    else if (addr == AW'(OFF_MSET))  sel = SEL_MSET;
    else if (addr == AW'(OFF_STAT))  sel = SEL_STAT;
    else if (addr == AW'(OFF_TYPE))  sel = SEL_TYPE;
    else if (addr == AW'(OFF_POL))   sel = SEL_POL;
    else if (addr == AW'(OFF_BOTH))  sel = SEL_BOTH;
    else                             sel = SEL_NONE;
  end
endmodule

// File: rtl/pei_cfg.sv
module pei_cfg #(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  pei_pkg::reg_sel_e sel,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  typ_q,
  output logic [NPINS-1:0]  pol_q,
  output logic [NPINS-1:0]  both_q,
  output logic [NPINS-1:0]  mask_q,
  output logic [NPINS-1:0]  mask_d
);
  import pei_pkg::*;

  // Next mask value: unmask clears, mask-set sets, anything else holds
  always_comb begin
    mask_d = mask_q;
    if (wr_en && sel == SEL_UNMSK) mask_d = mask_q & ~wdata;
    if (wr_en && sel == SEL_MSET)  mask_d = mask_q | wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      typ_q  <= '0;
      pol_q  <= '0;
      both_q <= '0;
      mask_q <= '1;
    end else begin
      mask_q <= mask_d;
      if (wr_en && sel == SEL_TYPE) typ_q  <= wdata;
      if (wr_en && sel == SEL_POL)  pol_q  <= wdata;
      if (wr_en && sel == SEL_BOTH) both_q <= wdata;
    end
  end
endmodule

// File: rtl/pei_detect.sv
module pei_detect #(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_i,
  input  logic [NPINS-1:0]  typ_q,
  input  logic [NPINS-1:0]  pol_q,
  input  logic [NPINS-1:0]  both_q,
  output logic [NPINS-1:0]  evt
);
  logic [NPINS-1:0] hist_q;

  // One-cycle history; frozen while reset is held
  always_ff @(posedge clk) begin
    if (!rst) hist_q <= pin_i;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, lvl;
    always_comb begin
      rise = pin_i[i] & ~hist_q[i];
      fall = ~pin_i[i] & hist_q[i];
      lvl  = ~(pin_i[i] ^ pol_q[i]);
      if (!typ_q[i])      evt[i] = lvl;
      else if (both_q[i]) evt[i] = rise | fall;
      else if (pol_q[i])  evt[i] = rise;
      else                evt[i] = fall;
    end
  end
endmodule

// File: rtl/pei_status.sv
module pei_status #(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_en,
  input  logic [NPINS-1:0]  wdata,
  input  logic [NPINS-1:0]  evt,
  input  logic [NPINS-1:0]  mask_d,
  output logic [NPINS-1:0]  stat_q,
  output logic              irq_q
);
  logic [NPINS-1:0] clr, stat_d;

  always_comb begin
    clr    = clr_en ? wdata : '0;
    stat_d = (stat_q & ~clr) | evt;   // new event beats a clear
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= |(stat_d & ~mask_d);
    end
  end
endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq #(
  parameter int NPINS = 32,
  parameter int AW    = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] rdata,
  output logic             irq
);
  import pei_pkg::*;

  reg_sel_e         sel;
  logic [NPINS-1:0] typ_q, pol_q, both_q, mask_q, mask_d;
  logic [NPINS-1:0] evt, status_q;
  logic [NPINS-1:0] rd_mux;

  pei_decode #(.AW(AW)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  pei_cfg #(.NPINS(NPINS)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .sel    (sel),
    .wdata  (wdata),
    .typ_q  (typ_q),
    .pol_q  (pol_q),
    .both_q (both_q),
    .mask_q (mask_q),
    .mask_d (mask_d)
  );

  pei_detect #(.NPINS(NPINS)) u_det (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pin_i),
    .typ_q  (typ_q),
    .pol_q  (pol_q),
    .both_q (both_q),
    .evt    (evt)
  );

  pei_status #(.NPINS(NPINS)) u_sts (
    .clk    (clk),
    .rst    (rst),
    .clr_en (wr_en && sel == SEL_STAT),
    .wdata  (wdata),
    .evt    (evt),
    .mask_d (mask_d),
    .stat_q (status_q),
    .irq_q  (irq)
  );

  always_comb begin
    unique case (sel)
      SEL_MASK: rd_mux = mask_q;
      SEL_STAT: rd_mux = status_q;
      SEL_TYPE: rd_mux = typ_q;
      SEL_POL:  rd_mux = pol_q;
      SEL_BOTH: rd_mux = both_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/pei_checker.sv
module pei_checker #(
  parameter int NPINS = 32,
  parameter int AW    = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [NPINS-1:0] wdata,
  input logic [NPINS-1:0] pin_i,
  input logic             irq,
  input logic [NPINS-1:0] status,
  input logic [NPINS-1:0] mask,
  input logic [NPINS-1:0] cfg_type,
  input logic [NPINS-1:0] cfg_pol
);
  import pei_pkg::*;

  logic             wr_stat, wr_unmsk, wr_mset;
  logic [NPINS-1:0] lvl_act;

  assign wr_stat  = wr_en && addr == AW'(OFF_STAT);
  assign wr_unmsk = wr_en && addr == AW'(OFF_UNMSK);
  assign wr_mset  = wr_en && addr == AW'(OFF_MSET);
  assign lvl_act  = ~cfg_type & ~(pin_i ^ cfg_pol);

  AST_IRQ_EQ_PENDING: assert property (@(posedge clk) disable iff (rst)
    irq == |(status & ~mask));  // R9

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !wr_stat |=> ((status & $past(status)) == $past(status)));  // R6

  AST_MASK_ONLY_BY_PORTS: assert property (@(posedge clk) disable iff (rst)
    !(wr_unmsk || wr_mset) |=> $stable(mask));  // R8

  AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wr_unmsk |=> ((mask & $past(wdata)) == '0));  // R8

  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (|lvl_act) |=> ((status & $past(lvl_act)) == $past(lvl_act)));  // R5
endmodule

bind pin_event_irq pei_checker #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .pin_i    (pin_i),
  .irq      (irq),
  .status   (status_q),
  .mask     (mask_q),
  .cfg_type (typ_q),
  .cfg_pol  (pol_q)
);

// File: tb/sim_pin_event_irq.sv
module sim_pin_event_irq;
  localparam int N  = 32;
  localparam int AW = 12;
  localparam logic [AW-1:0] A_MASK  = 12'h20C;
  localparam logic [AW-1:0] A_UNMSK = 12'h210;
  localparam logic [AW-1:0] A_MSET  = 12'h214;
  localparam logic [AW-1:0] A_STAT  = 12'h218;
  localparam logic [AW-1:0] A_TYPE  = 12'h21C;
  localparam logic [AW-1:0] A_POL   = 12'h220;
  localparam logic [AW-1:0] A_BOTH  = 12'h224;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic          rst;
  logic [N-1:0]  pins;
  logic          wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [N-1:0]  wdata, rdata;
  logic          irq;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  pin_event_irq #(.NPINS(N), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .pin_i(pins), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [N-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [N-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic setpins(logic [N-1:0] v);
    @(negedge clk); pins = v;
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    chk("R1 irq", N'(irq), '0);
    rd(A_MASK, d); chk("R1 mask", d, '1);
    rd(A_STAT, d); chk("R1 status", d, '0);
    rd(A_TYPE, d); chk("R1 type", d, '0);
    rd(A_POL,  d); chk("R1 pol", d, '0);
    rd(A_BOTH, d); chk("R1 both", d, '0);
  endtask

  task automatic t_regs();
    logic [N-1:0] d;
    wr(A_TYPE, '1);
    wr(A_POL, 32'h1234_5678);
    wr(A_BOTH, 32'h0F0F_0F0F);
    rd(A_TYPE, d); chk("R2 type", d, '1);
    rd(A_POL,  d); chk("R2 pol", d, 32'h1234_5678);
    rd(A_BOTH, d); chk("R2 both", d, 32'h0F0F_0F0F);
    rd(A_UNMSK, d); chk("R2 unmask reads 0", d, '0);
    rd(A_MSET,  d); chk("R2 mset reads 0", d, '0);
    wr(A_POL, '0);
    wr(A_BOTH, '0);
    rd(A_STAT, d); chk("R2 status quiet", d, '0);
  endtask

  task automatic t_edge();
    logic [N-1:0] d;
    wr(A_POL, 32'h1);
    setpins(pins & ~32'h3);
    rd(A_STAT, d); chk("R3 fall", d, 32'h2);
    setpins(pins | 32'h3);
    rd(A_STAT, d); chk("R3 rise", d, 32'h3);
    chk("R10 masked irq low", N'(irq), '0);
    wr(A_STAT, '1);
    rd(A_STAT, d); chk("R6 clear all", d, '0);
    wr(A_POL, '0);
  endtask

  task automatic t_mask();
    logic [N-1:0] d;
    wr(A_UNMSK, 32'h2);
    rd(A_MASK, d); chk("R8 unmask", d, 32'hFFFF_FFFD);
    chk("R9 irq idle", N'(irq), '0);
    setpins(pins & ~32'h2);
    @(negedge clk); chk("R9 irq up", N'(irq), 1);
    wr(A_MSET, 32'h2);
    chk("R9 irq masked", N'(irq), '0);
    rd(A_MASK, d); chk("R8 mset", d, '1);
    wr(A_MASK, '0);
    rd(A_MASK, d); chk("R8 direct write ignored", d, '1);
    wr(A_UNMSK, '0);
    rd(A_MASK, d); chk("R8 zero write", d, '1);
    wr(A_UNMSK, 32'h2);
    chk("R10 unmask latched", N'(irq), 1);
    setpins(pins | 32'h2);
    wr(A_STAT, '1);
    chk("R9 irq after clear", N'(irq), '0);
    wr(A_UNMSK, '1);
    wr(A_MSET, '1);
    rd(A_MASK, d); chk("R8 mask all", d, '1);
  endtask

  task automatic t_both();
    logic [N-1:0] d;
    wr(A_BOTH, 32'h4);
    setpins(pins & ~32'h4);
    rd(A_STAT, d); chk("R4 fall", d, 32'h4);
    wr(A_STAT, '1);
    setpins(pins | 32'h4);
    rd(A_STAT, d); chk("R4 rise pol0", d, 32'h4);
    wr(A_STAT, '1);
    wr(A_BOTH, 32'hC);
    wr(A_POL, 32'h8);
    wr(A_TYPE, ~32'h8);
    rd(A_STAT, d); chk("R4 level high", d, 32'h8);
    setpins(pins & ~32'h8);
    wr(A_STAT, '1);
    rd(A_STAT, d); chk("R4 no edge on level", d, '0);
    wr(A_BOTH, '0);
    wr(A_POL, '0);
    wr(A_TYPE, '1);
    setpins(pins | 32'h8);
    wr(A_STAT, '1);
  endtask

  task automatic t_level();
    logic [N-1:0] d;
    wr(A_TYPE, ~32'h10);
    rd(A_STAT, d); chk("R5 inactive", d, '0);
    setpins(pins & ~32'h10);
    rd(A_STAT, d); chk("R5 active", d, 32'h10);
    wr(A_STAT, 32'h10);
    rd(A_STAT, d); chk("R5 clear while held", d, 32'h10);
    setpins(pins | 32'h10);
    wr(A_STAT, 32'h10);
    rd(A_STAT, d); chk("R5 clear released", d, '0);
    wr(A_TYPE, '1);
  endtask

  task automatic t_partial();
    logic [N-1:0] d;
    setpins(pins & ~32'h6);
    rd(A_STAT, d); chk("R6 two set", d, 32'h6);
    wr(A_STAT, 32'h2);
    rd(A_STAT, d); chk("R6 partial", d, 32'h4);
    setpins(pins | 32'h6);
    wr(A_STAT, '1);
  endtask

  task automatic t_collide();
    logic [N-1:0] d;
    wr(A_POL, 32'h20);
    setpins(pins & ~32'h20);
    wr(A_STAT, '1);
    @(negedge clk);
    pins = pins | 32'h20; wr_en = 1'b1; addr = A_STAT; wdata = 32'h20;
    @(negedge clk); wr_en = 1'b0;
    rd(A_STAT, d); chk("R7 event wins", d, 32'h20);
    wr(A_STAT, '1);
    rd(A_STAT, d); chk("R7 later clear", d, '0);
    wr(A_POL, '0);
  endtask

  initial begin
    rst = 1'b1; pins = '1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_edge();
    t_mask();
    t_both();
    t_level();
    t_partial();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule